// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Controller

This block is the slave side of a small three-wire serial memory. A host frames each transaction with chip select, clocks bits in on a serial clock and reads results back on a data-out pin with a separate output enable that stands for the high-impedance state. The block decodes a one-bit start marker, a two-bit opcode and an address. It supports single and streaming reads, word writes, page writes, erasing one location, erasing everything, writing one word to everything, and turning the write-enable latch on and off. A width-select input chooses between 8-bit and 16-bit words over the same 128-byte store.

The serial pins are oversampled on a fast system clock. Serial-clock edges are found by comparing each sample with the one taken the cycle before. Program and erase commands are collected while chip select is high, staged in a 16-byte page buffer, and committed to the store in the clock where chip select falls. A self-timed busy window of a set number of system clocks follows. When chip select is raised again, data-out reports busy (0) or ready (1) until the host clears the flag.

Top module: `mw_eeprom_slave`

## Requirements
- R1: A frame starts at the first serial-clock rising edge with data-in at 1. Zeros before it are skipped. The next two bits are the opcode: 10 read, 01 write, 11 erase, 00 extended group.
- R2: With wide_i at 1 (16-bit words), the address is 6 bits and word n covers bytes 2n (upper half) and 2n+1. With wide_i at 0, the address is 7 bits and selects one byte.
- R3: After the last address bit of a read, data-out is enabled and shows a single 0. Each later rising edge shifts out the next bit of the word, MSB first.
- R4: While chip select stays high, a read continues with the next word and no leading 0. After the last word it wraps to word 0.
- R5: The write-enable latch is clear after reset. In the extended group, address top bits 11 set it and 00 clear it. While it is clear, write, erase, erase-all and write-all change nothing and start no busy window. Reads work in both states.
- R6: A complete write replaces the addressed word when chip select falls, with no erase needed first.
- R7: Erase sets the addressed word to all ones. Erase-all (extended top bits 10) sets every byte to all ones.
- R8: Write-all (extended top bits 01, then one data word) stores that word in every word location.
- R9: Each further data word in a write goes to the next word address. Words after the first 16 bytes wrap inside the aligned 16-byte page and overwrite earlier words.
- R10: A launched program makes data-out show 0 for BUSY_CYCLES system clocks when chip select is high, then 1. A rising serial-clock edge with data-in at 1, followed by a falling edge, turns data-out off.
- R11: While wr_lock_i is high when chip select falls, no program or erase takes place.
- R12: Output enable is low whenever chip select is low. A command cut short by chip select falling has no effect.
- R13: Command bits that arrive during the busy window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select; high frames a transaction |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| wide_i | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| wr_lock_i | input | 1 | Supply-low lockout; blocks programming |
| do_o | output | 1 | Serial data out / ready flag |
| do_oe_o | output | 1 | Output enable for do_o (low means high impedance) |

## Verification
The assertions assume that each serial-clock phase lasts at least two system clocks, that chip select and data-in change only while the serial clock is low, and that wide_i stays fixed within a frame. The stimulus drives every pin on the falling system-clock edge, with a four-clock serial period (two low, two high), and changes wide_i only while chip select is low. Frames that must be ignored during the busy window are kept shorter than that window, so the ignore rule is tested without mixing in a mid-frame restart.

// File: rtl/mw_pkg.sv
// Shared types for the three-wire serial EEPROM slave.
package mw_pkg;
    // Frame decoder states
    typedef enum logic [2:0] {
        FE_IDLE, FE_OPC, FE_ADDR, FE_RDATA, FE_WDATA, FE_DONE
    } fe_state_e;

    // Kind of program operation waiting for chip select to fall
    typedef enum logic [2:0] {
        PG_NONE, PG_WORD, PG_ERASE, PG_ERAL, PG_WRAL
    } prog_kind_e;
endpackage

// File: rtl/mw_frontend.sv
// Frame decoder: takes in the start bit, opcode, address and data on
// serial-clock rising edges, streams read data out, and records the
// program operation that is waiting for chip select to fall.
// Assumes: sk_rise is a one-cycle pulse; reset, deselect or hold
// returns the decoder to idle.
module mw_frontend
    import mw_pkg::*;
#(
    parameter int unsigned ABITS = 7,
    parameter int unsigned PBITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             sk_rise,
    input  logic             hold,
    input  logic             di,
    input  logic             wide,
    input  logic [15:0]      rd_word,
    output logic [ABITS-1:0] rd_addr,
    output logic             do_bit,
    output logic             do_en,
    output prog_kind_e       cmd_kind,
    output logic [ABITS-1:0] cmd_addr,
    output logic [15:0]      cmd_data,
    output logic             pb_we,
    output logic [ABITS-1:0] pb_addr,
    output logic [15:0]      pb_data,
    output logic             wen_set,
    output logic             wen_clr
);
    localparam int unsigned CW = 5;

    fe_state_e        state;
    logic [CW-1:0]    cnt;
    logic [1:0]       opc;
    logic [ABITS-2:0] ab;
    logic [14:0]      dsh;
    logic [ABITS-1:0] addr;

    logic [CW-1:0]    aw, dw;
    logic [ABITS-1:0] ab_n, baddr, seq_next, page_next;
    logic [1:0]       ext;
    logic [15:0]      d_n, d_word;
    logic             bit_cur;

    // Field lengths, the address being formed, and the next addresses
    always_comb begin
        aw        = wide ? CW'(ABITS - 1) : CW'(ABITS);
        dw        = wide ? CW'(16) : CW'(8);
        ab_n      = {ab, di};
        baddr     = wide ? {ab_n[ABITS-2:0], 1'b0} : ab_n;
        ext       = wide ? ab_n[ABITS-2 -: 2] : ab_n[ABITS-1 -: 2];
        d_n       = {dsh, di};
        d_word    = wide ? d_n : {d_n[7:0], 8'h00};
        seq_next  = addr + (wide ? ABITS'(2) : ABITS'(1));
        page_next = {addr[ABITS-1:PBITS],
                     addr[PBITS-1:0] + (wide ? PBITS'(2) : PBITS'(1))};
        bit_cur   = rd_word[4'(5'd15 - cnt)];
    end

    assign rd_addr = addr;

    // Frame sequencing on each serial-clock rising edge
    always_ff @(posedge clk) begin
        pb_we   <= 1'b0;
        wen_set <= 1'b0;
        wen_clr <= 1'b0;
        if (!rst_n || !cs || hold) begin
            state    <= FE_IDLE;
            cnt      <= '0;
            opc      <= '0;
            ab       <= '0;
            dsh      <= '0;
            addr     <= '0;
            do_en    <= 1'b0;
            do_bit   <= 1'b0;
            cmd_kind <= PG_NONE;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else if (sk_rise) begin
            case (state)
                FE_IDLE: if (di) begin
                    state <= FE_OPC;
                    cnt   <= '0;
                end
                FE_OPC: begin
                    opc <= {opc[0], di};
                    if (cnt == CW'(1)) begin
                        state <= FE_ADDR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                FE_ADDR: begin
                    ab <= ab_n[ABITS-2:0];
                    if (cnt == aw - CW'(1)) begin
                        cnt  <= '0;
                        addr <= baddr;
                        case (opc)
                            2'b10: begin
                                state  <= FE_RDATA;
                                do_en  <= 1'b1;
                                do_bit <= 1'b0;
                            end
                            2'b01: state <= FE_WDATA;
                            2'b11: begin
                                state    <= FE_DONE;
                                cmd_kind <= PG_ERASE;
                                cmd_addr <= baddr;
                            end
                            default: begin
                                case (ext)
                                    2'b11: begin wen_set <= 1'b1; state <= FE_DONE; end
                                    2'b00: begin wen_clr <= 1'b1; state <= FE_DONE; end
                                    2'b10: begin cmd_kind <= PG_ERAL; state <= FE_DONE; end
                                    default: state <= FE_WDATA;
                                endcase
                            end
                        endcase
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                FE_RDATA: begin
                    do_bit <= bit_cur;
                    if (cnt == dw - CW'(1)) begin
                        cnt  <= '0;
                        addr <= seq_next;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                FE_WDATA: begin
                    dsh <= d_n[14:0];
                    if (cnt == dw - CW'(1)) begin
                        cnt <= '0;
                        if (opc == 2'b01) begin
                            pb_we    <= 1'b1;
                            pb_addr  <= addr;
                            pb_data  <= d_word;
                            addr     <= page_next;
                            cmd_kind <= PG_WORD;
                        end else begin
                            cmd_kind <= PG_WRAL;
                            cmd_data <= d_word;
                            state    <= FE_DONE;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: a read always opens with a 0 before any data bit
    p_dummy_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_en) |-> !do_bit);

    // R12: after a deselect the decoder holds nothing
    p_clear_on_deselect_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (!do_en && cmd_kind == PG_NONE));
endmodule

// File: rtl/mw_store.sv
// Byte-wide storage with a one-page staging buffer. Write data is
// staged during the frame and applied with erase, erase-all or
// write-all in the single clock where commit is high.
// Assumes: all staged words lie in one aligned page, and the buffer
// is cleared while chip select is low.
module mw_store
    import mw_pkg::*;
#(
    parameter int unsigned ABITS = 7,
    parameter int unsigned PBITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic             pb_clr,
    input  logic             pb_we,
    input  logic [ABITS-1:0] pb_addr,
    input  logic [15:0]      pb_data,
    input  logic             commit,
    input  prog_kind_e       kind,
    input  logic [ABITS-1:0] cmd_addr,
    input  logic [15:0]      cmd_data,
    input  logic [ABITS-1:0] rd_addr,
    output logic [15:0]      rd_word
);
    localparam int unsigned DEPTH  = 1 << ABITS;
    localparam int unsigned PDEPTH = 1 << PBITS;

    logic [7:0]             mem  [DEPTH];
    logic [7:0]             pbuf [PDEPTH];
    logic [PDEPTH-1:0]      pmask;
    logic [ABITS-PBITS-1:0] pbase;
    logic [PBITS-1:0]       pidx;

    assign pidx    = pb_addr[PBITS-1:0];
    assign rd_word = {mem[rd_addr], mem[{rd_addr[ABITS-1:1], 1'b1}]};

    // Array contents: set to erased on reset, changed only at commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            case (kind)
                PG_WORD: begin
                    for (int i = 0; i < PDEPTH; i++)
                        if (pmask[i]) mem[{pbase, PBITS'(i)}] <= pbuf[i];
                end
                PG_ERASE: begin
                    mem[cmd_addr] <= 8'hFF;
                    if (wide) mem[{cmd_addr[ABITS-1:1], 1'b1}] <= 8'hFF;
                end
                PG_ERAL: begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
                end
                PG_WRAL: begin
                    for (int i = 0; i < DEPTH; i++)
                        mem[i] <= (wide && (i % 2 == 1)) ? cmd_data[7:0] : cmd_data[15:8];
                end
                default: ;
            endcase
        end
    end

    // Page staging: record each received word and its byte lanes
    always_ff @(posedge clk) begin
        if (!rst_n || pb_clr) begin
            pmask <= '0;
            pbase <= '0;
        end else if (pb_we) begin
            pbuf[pidx]  <= pb_data[15:8];
            pmask[pidx] <= 1'b1;
            pbase       <= pb_addr[ABITS-1:PBITS];
            if (wide) begin
                pbuf[{pidx[PBITS-1:1], 1'b1}]  <= pb_data[7:0];
                pmask[{pidx[PBITS-1:1], 1'b1}] <= 1'b1;
            end
        end
    end

    // R9: staging only happens inside a selected frame, never at commit
    p_no_stage_at_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !pb_we);
endmodule

// File: rtl/mw_prog_timer.sv
// Self-timed program window and ready/busy reporting. A launch starts
// BUSY_CYCLES system clocks of busy and sets a pending flag. The flag
// shows status while chip select is high, and a 1 clocked in followed
// by a falling serial-clock edge clears it.
// Assumes: launch only while chip select is low.
module mw_prog_timer #(
    parameter int unsigned BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic cs,
    input  logic sk_rise,
    input  logic sk_fall,
    input  logic di,
    output logic busy,
    output logic st_show,
    output logic hold
);
    localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          pend;
    logic          arm;

    assign st_show = cs && pend;
    assign hold    = busy || pend;

    // Busy down-counter started by a launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            cnt  <= CW'(BUSY_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - CW'(1);
        end
    end

    // Status flag and its clear sequence (1 on rise, then a fall)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            arm  <= 1'b0;
        end else if (launch) begin
            pend <= 1'b1;
            arm  <= 1'b0;
        end else if (!cs) begin
            arm <= 1'b0;
        end else if (pend && sk_rise && di) begin
            arm <= 1'b1;
        end else if (arm && sk_fall) begin
            arm  <= 1'b0;
            pend <= 1'b0;
        end
    end

    // R10: a launch always opens a busy window with status pending
    p_launch_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && pend));

    // R13: no new launch can happen inside a running window
    p_no_launch_in_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !$rose(pend));
endmodule

// File: rtl/mw_eeprom_slave.sv
// Top level: finds serial-pin edges on the system clock, holds the
// write-enable latch, decides whether a collected command launches,
// and drives data-out from either the read path or the status flag.
// Assumes: each serial-clock phase lasts at least two system clocks,
// and chip select and data-in change only while the serial clock is low.
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int unsigned ABITS       = 7,
    parameter int unsigned PBITS       = 4,
    parameter int unsigned BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic wide_i,
    input  logic wr_lock_i,
    output logic do_o,
    output logic do_oe_o
);
    logic             sk_q, cs_q, wen_q;
    logic             sk_rise, sk_fall, cs_fall, launch;
    logic             tm_busy, tm_show, tm_hold;
    logic             fe_do_bit, fe_do_en, fe_pb_we, fe_wen_set, fe_wen_clr;
    prog_kind_e       fe_kind;
    logic [ABITS-1:0] fe_rd_addr, fe_cmd_addr, fe_pb_addr;
    logic [15:0]      fe_cmd_data, fe_pb_data, st_rd_word;

    // Previous pin samples, used to find edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk_i;
            cs_q <= cs_i;
        end
    end

    assign sk_rise = cs_i && sk_i && !sk_q;
    assign sk_fall = cs_i && !sk_i && sk_q;
    assign cs_fall = cs_q && !cs_i;
    assign launch  = cs_fall && (fe_kind != PG_NONE) && wen_q && !wr_lock_i && !tm_hold;

    // Write-enable latch: clear after reset, changed by extended commands
    always_ff @(posedge clk) begin
        if (!rst_n)          wen_q <= 1'b0;
        else if (fe_wen_set) wen_q <= 1'b1;
        else if (fe_wen_clr) wen_q <= 1'b0;
    end

    assign do_oe_o = cs_i && (fe_do_en || tm_show);
    assign do_o    = tm_show ? !tm_busy : fe_do_bit;

    mw_frontend #(.ABITS(ABITS), .PBITS(PBITS)) u_fe (
        .clk(clk), .rst_n(rst_n), .cs(cs_i), .sk_rise(sk_rise),
        .hold(tm_hold), .di(di_i), .wide(wide_i), .rd_word(st_rd_word),
        .rd_addr(fe_rd_addr), .do_bit(fe_do_bit), .do_en(fe_do_en),
        .cmd_kind(fe_kind), .cmd_addr(fe_cmd_addr), .cmd_data(fe_cmd_data),
        .pb_we(fe_pb_we), .pb_addr(fe_pb_addr), .pb_data(fe_pb_data),
        .wen_set(fe_wen_set), .wen_clr(fe_wen_clr)
    );

    mw_store #(.ABITS(ABITS), .PBITS(PBITS)) u_store (
        .clk(clk), .rst_n(rst_n), .wide(wide_i), .pb_clr(!cs_i),
        .pb_we(fe_pb_we), .pb_addr(fe_pb_addr), .pb_data(fe_pb_data),
        .commit(launch), .kind(fe_kind), .cmd_addr(fe_cmd_addr),
        .cmd_data(fe_cmd_data), .rd_addr(fe_rd_addr), .rd_word(st_rd_word)
    );

    mw_prog_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cs(cs_i),
        .sk_rise(sk_rise), .sk_fall(sk_fall), .di(di_i),
        .busy(tm_busy), .st_show(tm_show), .hold(tm_hold)
    );

    // R5: a busy window only follows a command made while enabled
    p_wen_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tm_busy) |-> $past(wen_q));

    // R11: lockout at the deselect edge prevents the busy window
    p_lockout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tm_busy) |-> !$past(wr_lock_i));

    // R12: the read path is idle in the cycle after a deselect
    p_hiz_after_deselect_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_i && !cs_q) |-> !do_oe_o);
endmodule

// File: tb/mw_eeprom_slave_tb.sv
// Bench: a behavioural byte-array model with queued write data predicts
// every data-out bit; a per-clock monitor checks that the output is off
// while deselected.
module mw_eeprom_slave_tb_top;
    localparam int unsigned BUSY = 200;
    localparam int unsigned NB   = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, wide = 1'b1, lock = 1'b0;
    logic do_o, do_oe;
    int   n_chk = 0, n_err = 0;
    bit   done = 1'b0;

    logic [7:0]  mdl [NB];
    logic [7:0]  stg [NB];
    bit          stg_m [NB];
    bit          mwen = 1'b0;
    logic [15:0] nodata [$];

    always #2 clk = ~clk;

    mw_eeprom_slave #(.ABITS(7), .PBITS(4), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .wide_i(wide), .wr_lock_i(lock), .do_o(do_o), .do_oe_o(do_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R12: output off on every clock while deselected
    always @(posedge clk) begin
        if (rst_n && !cs && !done) chk("R12 oe while deselected", {31'd0, do_oe}, 32'd0);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic o, output logic oe);
        sk = 1'b0; di = b; tick(2);
        sk = 1'b1; tick(1);
        o = do_o; oe = do_oe;
        tick(1);
    endtask

    task automatic send(input logic [31:0] v, input int n, output logic o, output logic oe);
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i], o, oe);
    endtask

    function automatic int aw(input logic w);
        return w ? 6 : 7;
    endfunction

    task automatic cs_on(input logic w);
        wide = w; cs = 1'b1; tick(2);
    endtask

    task automatic cs_off();
        sk = 1'b0; tick(1); cs = 1'b0; di = 1'b0; tick(3);
    endtask

    task automatic header(input logic w, input logic [1:0] opc, input int a,
                          output logic o, output logic oe);
        send(1, 1, o, oe);
        send({30'd0, opc}, 2, o, oe);
        send(a, aw(w), o, oe);
    endtask

    function automatic logic [15:0] mword(input logic w, input int a);
        if (w) return {mdl[2*a], mdl[2*a+1]};
        return {8'h00, mdl[a]};
    endfunction

    // R1/R3/R4: read nw words from a, with a leading zero before start
    task automatic do_read(input string req, input logic w, input int a, input int nw);
        logic o, oe;
        logic [15:0] wv;
        int dw = w ? 16 : 8;
        int nwords = w ? 64 : 128;
        cs_on(w);
        send(0, 1, o, oe);
        header(w, 2'b10, a, o, oe);
        chk({req, " R3 dummy"}, {30'd0, oe, o}, 32'd2);
        for (int k = 0; k < nw; k++) begin
            wv = mword(w, a);
            for (int b = dw - 1; b >= 0; b--) begin
                clk_bit(1'b0, o, oe);
                chk({req, " R3 bit"}, {30'd0, oe, o}, {30'd0, 1'b1, wv[b]});
            end
            a = (a + 1) % nwords;
        end
        cs_off();
    endtask

    task automatic frame(input logic w, input logic [1:0] opc, input int a,
                         input logic [15:0] dq[$]);
        logic o, oe;
        cs_on(w);
        header(w, opc, a, o, oe);
        foreach (dq[k]) send(w ? {16'd0, dq[k]} : {24'd0, dq[k][7:0]}, w ? 16 : 8, o, oe);
        cs_off();
    endtask

    // R10: status shows busy, turns ready after BUSY clocks, then clears
    task automatic status(input string req, input logic launched);
        logic o, oe;
        cs_on(wide);
        if (!launched) begin
            chk({req, " R10 no status"}, {31'd0, do_oe}, 32'd0);
        end else begin
            chk({req, " R10 busy"}, {30'd0, do_oe, do_o}, 32'd2);
            tick(BUSY - 12);
            chk({req, " R10 still busy"}, {30'd0, do_oe, do_o}, 32'd2);
            tick(12);
            chk({req, " R10 ready"}, {30'd0, do_oe, do_o}, 32'd3);
            clk_bit(1'b1, o, oe);
            sk = 1'b0; tick(2);
            chk({req, " R10 cleared"}, {31'd0, do_oe}, 32'd0);
        end
        cs_off();
    endtask

    function automatic bit can_prog();
        return mwen && !lock;
    endfunction

    task automatic stage_clear();
        for (int i = 0; i < NB; i++) stg_m[i] = 1'b0;
    endtask

    task automatic stage_commit();
        for (int i = 0; i < NB; i++) if (stg_m[i]) mdl[i] = stg[i];
    endtask

    // R6/R9: write words from a, wrapping inside the 16-byte page
    task automatic write_cmd(input string req, input logic w, input int a, input logic [15:0] dq[$]);
        int ba = w ? 2 * a : a;
        int st = w ? 2 : 1;
        bit go = can_prog();
        stage_clear();
        foreach (dq[k]) begin
            if (w) begin
                stg[ba] = dq[k][15:8]; stg_m[ba] = 1'b1;
                stg[ba+1] = dq[k][7:0]; stg_m[ba+1] = 1'b1;
            end else begin
                stg[ba] = dq[k][7:0]; stg_m[ba] = 1'b1;
            end
            ba = (ba & ~15) | ((ba + st) & 15);
        end
        frame(w, 2'b01, a, dq);
        if (go) stage_commit();
        status(req, go);
    endtask

    task automatic ext_cmd(input logic w, input logic [1:0] code, input logic [15:0] dq[$]);
        frame(w, 2'b00, int'(code) << (aw(w) - 2), dq);
    endtask

    initial begin : main
        logic [15:0] q [$];
        logic o, oe;
        for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        chk("R12 reset oe", {31'd0, do_oe}, 32'd0);

        do_read("R2 R3 erased x16", 1'b1, 0, 1);

        // R5: write before enable is ignored
        q = '{16'hBEEF};
        write_cmd("R5 disabled", 1'b1, 3, q);
        do_read("R5 disabled readback", 1'b1, 3, 1);

        ext_cmd(1'b1, 2'b11, nodata); mwen = 1'b1;

        q = '{16'hA5C3};
        write_cmd("R6 word", 1'b1, 5, q);
        do_read("R6 R2 x16 readback", 1'b1, 5, 1);

        q = '{16'h003C};
        write_cmd("R2 byte", 1'b0, 8'h13, q);
        do_read("R2 x8 readback", 1'b0, 8'h13, 1);
        do_read("R2 x16 of byte pair", 1'b1, 9, 1);

        q = '{16'h1234};
        write_cmd("R6 overwrite", 1'b1, 5, q);
        do_read("R6 overwrite readback", 1'b1, 5, 1);

        frame(1'b1, 2'b11, 5, nodata);
        mdl[10] = 8'hFF; mdl[11] = 8'hFF;
        status("R7 erase", 1'b1);
        do_read("R7 erase readback", 1'b1, 5, 1);

        // R9: 18 bytes from 0x2E wrap inside page 0x20..0x2F
        q = {};
        for (int k = 0; k < 18; k++) q.push_back(16'(8'h40 + k));
        write_cmd("R9 page x8", 1'b0, 8'h2E, q);
        do_read("R9 R4 page readback", 1'b0, 8'h20, 16);

        q = '{16'h7701, 16'h7702, 16'h7703};
        write_cmd("R9 page x16", 1'b1, 62, q);
        do_read("R4 wrap to 0", 1'b1, 62, 4);

        lock = 1'b1;
        q = '{16'hDEAD};
        write_cmd("R11 lockout", 1'b1, 7, q);
        lock = 1'b0;
        do_read("R11 readback", 1'b1, 7, 1);

        // R12: cut-short write has no effect
        cs_on(1'b1);
        header(1'b1, 2'b01, 7, o, oe);
        send(16'hFF, 9, o, oe);
        cs_off();
        status("R12 partial", 1'b0);
        do_read("R12 partial readback", 1'b1, 7, 1);

        ext_cmd(1'b0, 2'b00, nodata); mwen = 1'b0;
        frame(1'b1, 2'b11, 5, nodata);
        status("R5 erase disabled", 1'b0);
        do_read("R5 read while disabled", 1'b1, 5, 1);

        ext_cmd(1'b1, 2'b11, nodata); mwen = 1'b1;
        q = '{16'h5AA5};
        ext_cmd(1'b1, 2'b01, q);
        for (int i = 0; i < NB; i++) mdl[i] = (i % 2 == 1) ? 8'hA5 : 8'h5A;
        status("R8 write-all", 1'b1);
        do_read("R8 write-all readback", 1'b1, 0, 3);
        do_read("R8 write-all far", 1'b1, 40, 1);

        // R7/R13: erase-all, then a write sent during busy is ignored
        ext_cmd(1'b1, 2'b10, nodata);
        for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
        cs_on(1'b1);
        chk("R13 busy before ignored frame", {30'd0, do_oe, do_o}, 32'd2);
        cs_off();
        q = '{16'h1111};
        frame(1'b1, 2'b01, 2, q);
        tick(BUSY);
        status("R13 no relaunch", 1'b0);
        do_read("R7 R13 erase-all readback", 1'b1, 2, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule